// File: doc/BRIEF.md
# Light-Load Frequency-Dithering Cycle Generator

This block sets the switching rhythm of a peak-current-mode flyback controller. A fast system clock drives it. It compares a digitized feedback code against two thresholds and, at the start of every switching cycle, chooses a cycle length in clock counts. The block then emits a single-clock start strobe at that spacing. It also reports the cycle length that is currently in force, so the gate logic and the slope generator downstream can scale their ramps to it.

At normal load the cycle length is the nominal period plus a slowly sweeping triangular offset. This spreads the switching energy over a band of frequencies. When the feedback falls into the light-load window, the dither stops. The frequency then falls linearly with the feedback code until it reaches a fixed floor just above the audible band. Every new length takes effect only at a cycle boundary, so a cycle that is already running is never cut short. With the default parameters (50 MHz clock) the nominal cycle is 769 counts (65 kHz). The dither is about ±48 counts and sweeps once in roughly 4.3 ms. The floor is 2777 counts (just above 18 kHz). Light load starts below code 107 and reaches the floor at code 82.

Top module: `gm_cycle_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `cyc_start` is 0 and `active_period` equals the nominal period NOM = CLK_HZ / F_NOM (integer division), whatever the feedback code is. On the first clock edge with `rst_n` high, a new cycle begins and `cyc_start` is 1.
- R2: `cyc_start` is high for exactly one clock. Two consecutive strobes are exactly `active_period` clocks apart, where `active_period` is the value that appeared together with the earlier strobe.
- R3: The feedback code sampled on the clock edge that raises `cyc_start` selects that cycle's length. A change of `fb_code` in the middle of a cycle does not change the spacing to the next strobe.
- R4: When `fb_code` >= FB_ENTRY (unsigned compare), the cycle length is NOM + H. H is the integer dither offset defined in R5.
- R5: The dither keeps an accumulator A in units of 2^-HOP_FRAC_W counts. A is 0 after reset. A moves by HOP_STEP at every strobe, after the current cycle has used it. It rises first. On reaching +HOP_AMP it is clamped there and turns downward. On reaching -HOP_AMP it is clamped and turns upward. A move that would pass the limit lands on the limit. The offset is H = floor(A / 2^HOP_FRAC_W).
- R6: When FB_END < `fb_code` < FB_ENTRY, the cycle length is CLK_HZ / (F_NOM - (k*(F_NOM - F_MIN)) / SPAN), with k = FB_ENTRY - fb_code, SPAN = FB_ENTRY - FB_END, and integer division throughout. No dither is added.
- R7: When `fb_code` <= FB_END, the cycle length is CLK_HZ / F_MIN, the floor. No strobe ever reports a length greater than this floor.
- R8: The dither accumulator advances on every strobe, light-load cycles included. After a return to normal load, the offset continues from where the sweep has reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fb_code | input | FB_W | Digitized feedback voltage, 0 to full scale |
| cyc_start | output | 1 | One-clock strobe that marks the start of a switching cycle |
| active_period | output | PERIOD_W | Length in clocks of the cycle that is running |

## Verification
The bench sweeps the dither through several full triangles with an odd fractional step. A design that floored negative offsets toward zero, or that reversed one step late, would report a period one count off at the turning points. The bench also sets feedback codes exactly on both thresholds, one code inside them, and far below the floor. An off-by-one compare would then apply dither at the lowest light-load code, or would stop one code short of the floor. The bench changes the feedback mid-cycle to catch a design that reloads its length early and truncates the running cycle. It resets the design while in light load and checks that the nominal length returns at once, and that the sweep restarts from zero.

// File: rtl/gm_pkg.sv
// Package: shared types and constant math for the cycle generator.
// Assumes all frequencies are in Hz and fit a 32-bit int.
package gm_pkg;

    typedef enum logic {
        HOP_RISE = 1'b0,
        HOP_FALL = 1'b1
    } hop_dir_e;

    // Cycle length in clocks for light-load step k of span steps.
    function automatic int green_cycles(input int clk_hz, input int f_nom,
                                        input int f_min, input int k,
                                        input int span);
        int f_k;
        f_k = f_nom - (k * (f_nom - f_min)) / span;
        return clk_hz / f_k;
    endfunction

endpackage

// File: rtl/gm_hop_gen.sv
// Triangular dither source. It holds a signed accumulator in fractional
// counts that moves one step per switching cycle and turns at +/-HOP_AMP.
// Assumes HOP_STEP <= HOP_AMP. The output is the accumulator floored to
// whole counts.
module gm_hop_gen #(
    parameter int HOP_FRAC_W = 4,
    parameter int HOP_AMP    = 768,
    parameter int HOP_STEP   = 11,
    parameter int ACC_W      = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    output logic signed [ACC_W-1:0] hop_off
);
    import gm_pkg::*;

    localparam logic signed [ACC_W-1:0] AMP_S  = ACC_W'(HOP_AMP);
    localparam logic signed [ACC_W-1:0] STEP_S = ACC_W'(HOP_STEP);

    logic signed [ACC_W-1:0] acc;
    hop_dir_e                dir;

    // Move the accumulator one step per cycle and reverse at the limits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            dir <= HOP_RISE;
        end else if (adv) begin
            if (dir == HOP_RISE) begin
                if (acc >= AMP_S - STEP_S) begin
                    acc <= AMP_S;
                    dir <= HOP_FALL;
                end else begin
                    acc <= acc + STEP_S;
                end
            end else begin
                if (acc <= STEP_S - AMP_S) begin
                    acc <= -AMP_S;
                    dir <= HOP_RISE;
                end else begin
                    acc <= acc - STEP_S;
                end
            end
        end
    end

    // Floor the fractional accumulator to whole clock counts.
    always_comb hop_off = acc >>> HOP_FRAC_W;

    // R5
    acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc <= AMP_S) && (acc >= -AMP_S));

    // R5
    top_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && acc == AMP_S) |=> (acc == AMP_S - STEP_S));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(acc));

endmodule

// File: rtl/gm_green_map.sv
// Light-load mapper. It turns the feedback code into a stretched cycle
// length through a table that is computed at elaboration, one entry per
// code step of the light-load window. Assumes FB_ENTRY > FB_END.
module gm_green_map #(
    parameter int CLK_HZ   = 50_000_000,
    parameter int F_NOM    = 65_000,
    parameter int F_MIN    = 18_000,
    parameter int FB_W     = 8,
    parameter int FB_ENTRY = 107,
    parameter int FB_END   = 82,
    parameter int PERIOD_W = 12
) (
    input  logic [FB_W-1:0]     fb_code,
    output logic                green,
    output logic [PERIOD_W-1:0] green_period
);
    localparam int SPAN = FB_ENTRY - FB_END;
    localparam int KW   = $clog2(SPAN + 1);

    logic [PERIOD_W-1:0] tbl [SPAN+1];
    logic [KW-1:0]       k;

    // One table entry per light-load step, computed from the frequency line.
    for (genvar i = 0; i <= SPAN; i++) begin : g_tbl
        assign tbl[i] = PERIOD_W'(gm_pkg::green_cycles(CLK_HZ, F_NOM, F_MIN, i, SPAN));
    end

    // Pick the step index: saturate at the floor, zero outside the window.
    always_comb begin
        green = (int'(fb_code) < FB_ENTRY);
        if (int'(fb_code) <= FB_END)
            k = KW'(SPAN);
        else if (green)
            k = KW'(FB_ENTRY - int'(fb_code));
        else
            k = '0;
        green_period = tbl[k];
    end

endmodule

// File: rtl/gm_period_ctr.sv
// Cycle counter. It counts one switching cycle and, at the wrap, loads
// the next length and raises a one-clock strobe. Assumes every length
// it is given is at least 2.
module gm_period_ctr #(
    parameter int PERIOD_W   = 12,
    parameter int RST_PERIOD = 769
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] next_period,
    output logic                wrap,
    output logic                strobe,
    output logic [PERIOD_W-1:0] period_q
);
    logic [PERIOD_W-1:0] cnt;

    // The last count of the running cycle ends it.
    always_comb wrap = (cnt >= period_q - PERIOD_W'(1));

    // Count the cycle, reload the length and pulse at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= PERIOD_W'(RST_PERIOD - 1);
            period_q <= PERIOD_W'(RST_PERIOD);
            strobe   <= 1'b0;
        end else if (wrap) begin
            cnt      <= '0;
            period_q <= next_period;
            strobe   <= 1'b1;
        end else begin
            cnt      <= cnt + PERIOD_W'(1);
            strobe   <= 1'b0;
        end
    end

    // R2
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R2
    strobe_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (cnt == '0));

    // R3
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !$rose(rst_n)) |-> $stable(period_q));

endmodule

// File: rtl/gm_cycle_gen.sv
// Top: switching-cycle generator with triangular dither and a light-load
// frequency fold-back down to a fixed floor. At each cycle boundary it
// picks either the nominal length plus the dither offset or the stretched
// light-load length. Assumes F_NOM > F_MIN and that the nominal length
// plus the largest dither stays under the floor length.
module gm_cycle_gen #(
    parameter int CLK_HZ     = 50_000_000,
    parameter int F_NOM      = 65_000,
    parameter int F_MIN      = 18_000,
    parameter int FB_W       = 8,
    parameter int FB_ENTRY   = 107,
    parameter int FB_END     = 82,
    parameter int HOP_FRAC_W = 4,
    parameter int HOP_AMP    = 768,
    parameter int HOP_STEP   = 11,
    parameter int PERIOD_W   = $clog2(CLK_HZ / F_MIN + (HOP_AMP >> HOP_FRAC_W) + 2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FB_W-1:0]     fb_code,
    output logic                cyc_start,
    output logic [PERIOD_W-1:0] active_period
);
    localparam int NOM_P   = CLK_HZ / F_NOM;
    localparam int FLOOR_P = CLK_HZ / F_MIN;
    localparam int ACC_W   = $clog2(HOP_AMP + HOP_STEP + 1) + 2;

    logic signed [ACC_W-1:0] hop_off;
    logic                    green;
    logic [PERIOD_W-1:0]     green_period;
    logic [PERIOD_W-1:0]     next_period;
    logic                    wrap;
    int                      nom_sum;

    gm_hop_gen #(
        .HOP_FRAC_W(HOP_FRAC_W),
        .HOP_AMP   (HOP_AMP),
        .HOP_STEP  (HOP_STEP),
        .ACC_W     (ACC_W)
    ) u_hop (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (wrap),
        .hop_off(hop_off)
    );

    gm_green_map #(
        .CLK_HZ  (CLK_HZ),
        .F_NOM   (F_NOM),
        .F_MIN   (F_MIN),
        .FB_W    (FB_W),
        .FB_ENTRY(FB_ENTRY),
        .FB_END  (FB_END),
        .PERIOD_W(PERIOD_W)
    ) u_green (
        .fb_code     (fb_code),
        .green       (green),
        .green_period(green_period)
    );

    // Choose the next cycle length: the stretched one or nominal plus dither.
    always_comb begin
        nom_sum     = NOM_P + int'(hop_off);
        next_period = green ? green_period : PERIOD_W'(nom_sum);
    end

    gm_period_ctr #(
        .PERIOD_W  (PERIOD_W),
        .RST_PERIOD(NOM_P)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .next_period(next_period),
        .wrap       (wrap),
        .strobe     (cyc_start),
        .period_q   (active_period)
    );

    // R7
    floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |-> (int'(active_period) <= FLOOR_P));

    // R1
    first_start_chk: assert property (@(posedge clk)
        $rose(rst_n) |=> cyc_start);

endmodule

// File: tb/sim_gm_cycle_gen.sv
// Directed bench for gm_cycle_gen, run with a short clock scale so that
// many dither sweeps fit. Each task drives one scenario and checks it.
module sim_gm_cycle_gen;
    localparam int CLK_HZ = 1_000_000;
    localparam int F_NOM  = 65_000;
    localparam int F_MIN  = 18_000;
    localparam int FB_W   = 8;
    localparam int ENTRY  = 107;
    localparam int FEND   = 82;
    localparam int FRAC   = 1;
    localparam int AMP    = 6;
    localparam int STEP   = 3;
    localparam int PW     = $clog2(CLK_HZ / F_MIN + (AMP >> FRAC) + 2);
    localparam int NOM    = CLK_HZ / F_NOM;
    localparam int FLOOR  = CLK_HZ / F_MIN;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [FB_W-1:0] fb = 8'd200;
    logic          cyc_start;
    logic [PW-1:0] active_period;

    int n_chk = 0, n_bad = 0;
    int cyc = 0, last_cyc = 0, prev_len = 0;
    bit have_prev = 0, done = 0;
    int m_acc = 0;
    bit m_up = 1;

    gm_cycle_gen #(
        .CLK_HZ(CLK_HZ), .F_NOM(F_NOM), .F_MIN(F_MIN), .FB_W(FB_W),
        .FB_ENTRY(ENTRY), .FB_END(FEND), .HOP_FRAC_W(FRAC),
        .HOP_AMP(AMP), .HOP_STEP(STEP), .PERIOD_W(PW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .fb_code(fb),
        .cyc_start(cyc_start), .active_period(active_period)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected length from the requirement formulas (R4, R6, R7).
    function automatic int exp_len(input int code);
        int k;
        if (code >= ENTRY) return NOM + (m_acc >>> FRAC);
        if (code <= FEND) return CLK_HZ / F_MIN;
        k = ENTRY - code;
        return CLK_HZ / (F_NOM - (k * (F_NOM - F_MIN)) / (ENTRY - FEND));
    endfunction

    // Dither model step (R5).
    task automatic model_step();
        if (m_up) begin
            if (m_acc >= AMP - STEP) begin m_acc = AMP; m_up = 0; end
            else m_acc += STEP;
        end else begin
            if (m_acc <= STEP - AMP) begin m_acc = -AMP; m_up = 1; end
            else m_acc -= STEP;
        end
    endtask

    // Wait for one strobe and check its spacing, length and width (R2).
    task automatic take_cycle(input string req);
        int e;
        do @(negedge clk); while (!cyc_start);
        e = exp_len(int'(fb));
        check(int'(active_period) == e, req, int'(active_period), e);
        if (have_prev)
            check(cyc - last_cyc == prev_len, "R2 spacing", cyc - last_cyc, prev_len);
        last_cyc = cyc; prev_len = e; have_prev = 1;
        model_step();
        @(negedge clk);
        check(cyc_start == 1'b0, "R2 width", int'(cyc_start), 0);
    endtask

    task automatic t_reset(input logic [FB_W-1:0] code);
        @(negedge clk);
        fb = code; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(cyc_start == 1'b0, "R1 strobe in reset", int'(cyc_start), 0);
        check(int'(active_period) == NOM, "R1 length in reset", int'(active_period), NOM);
        m_acc = 0; m_up = 1; have_prev = 0;
        rst_n = 1'b1;
        @(negedge clk);
        check(cyc_start == 1'b1, "R1 first strobe", int'(cyc_start), 1);
        begin
            int e = exp_len(int'(fb));
            check(int'(active_period) == e, "R1 first length", int'(active_period), e);
            last_cyc = cyc; prev_len = e; have_prev = 1;
        end
        model_step();
    endtask

    task automatic t_nominal();
        fb = 8'd200;
        for (int i = 0; i < 24; i++) take_cycle("R5 dither sweep");
        fb = 8'(ENTRY);
        for (int i = 0; i < 3; i++) take_cycle("R4 at entry code");
    endtask

    task automatic t_green();
        fb = 8'(ENTRY - 1); take_cycle("R6 first light-load code"); take_cycle("R6 first light-load code");
        fb = 8'd95;  take_cycle("R6 mid window"); take_cycle("R6 mid window");
        fb = 8'(FEND + 1); take_cycle("R6 last step"); take_cycle("R6 last step");
        fb = 8'(FEND); take_cycle("R7 at floor code"); take_cycle("R7 at floor code");
        fb = 8'd0; take_cycle("R7 below floor"); take_cycle("R7 below floor");
        check(int'(active_period) <= FLOOR, "R7 floor bound", int'(active_period), FLOOR);
    endtask

    task automatic t_midcycle();
        fb = 8'd200; take_cycle("R3 setup");
        repeat (4) @(negedge clk);
        fb = 8'd0;
        take_cycle("R3 mid-cycle change");
        repeat (5) @(negedge clk);
        fb = 8'd200;
        take_cycle("R3 mid-cycle change back");
    endtask

    task automatic t_hop_continues();
        fb = 8'd90;
        for (int i = 0; i < 5; i++) take_cycle("R8 light-load cycles");
        fb = 8'd250;
        for (int i = 0; i < 6; i++) take_cycle("R8 resume sweep");
    endtask

    initial begin
        t_reset(8'd200);
        t_nominal();
        t_green();
        t_midcycle();
        t_hop_continues();
        fb = 8'd0;
        take_cycle("R7 before reset");
        t_reset(8'd0);
        take_cycle("R1 after reset in light load");
        fb = 8'd200;
        for (int i = 0; i < 4; i++) take_cycle("R1 sweep restart");
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule